// File: doc/BRIEF.md
# Page Store Access Controller with Monotonic Locks

This block owns a small non-volatile page store of 16 pages of 4 bytes and serves the card-side protocol state machine. It answers page reads, ordinary page writes and the two-phase legacy write. It enforces which pages may be written. It also applies the rule that the lock and one-time-programmable areas can only gain set bits. The first nine bytes come from a factory serial number. The byte after them is reserved. The remaining two bytes of page 2 carry the lock configuration, page 3 is a one-time-programmable word, and pages 4 to 15 hold user data.

A request is one cycle on `req_valid`, carrying a command byte, a page address and a data frame. A read is answered one cycle later with four consecutive pages, and the address wraps past the last page. An accepted write raises `busy` for `BUSY_CYCLES` cycles, which stands in for programming time, and then commits the page and reports an acknowledge code. Rejections report a negative code one cycle after the request. Lock bits that are written go into the store at once, but the write-protection logic only uses them after the protocol layer pulses `lock_refresh`, which it does when a wake-up or request-type frame arrives.

Top module: `page_store_ctrl`

## Requirements
- R1: After reset, page 0 holds serial bytes SN0, SN1, SN2 and check byte CT^SN0^SN1^SN2 with CT = 88h; page 1 holds SN3..SN6; page 2 holds check byte SN3^SN4^SN5^SN6 in byte 0 and the reserved byte in byte 1; every other byte is 0. Byte n of a page sits at word bits [8n+7:8n]. `busy` and `rsp_valid` are low. Pages 0 and 1 and bytes 0–1 of page 2 never change.
- R2: Command 30h with an address of at most 0Fh returns, one cycle later, `rsp_valid`=1 and `rsp_is_data`=1. `rsp_data` holds pages a, a+1, a+2, a+3 taken modulo 16, with page a in bits [31:0].
- R3: Command 30h with an address above 0Fh returns the negative code 0h with `rsp_is_data`=0 one cycle later.
- R4: Command A2h to an unlocked page in the range 4–15 raises `busy` after the request edge and leaves `rsp_valid` low. It returns acknowledge code Ah exactly `BUSY_CYCLES` cycles after the request edge, and the page then holds data bits [31:0].
- R5: A write (A2h) to page 0 or 1, to an address above 0Fh, or to a page 3–15 whose effective lock bit is set returns code 0h one cycle later and changes nothing.
- R6: A write to page 3 stores the bitwise OR of the old contents and the new data.
- R7: A write to page 2 keeps bytes 0–1 and ORs data bytes 2–3 into the lock bytes. In byte 2, bit 0 freezes page 3's lock, bit 1 freezes locks 4–9, bit 2 freezes locks 10–15, bit 3 locks page 3, and bits 4–7 lock pages 4–7. In byte 3, bits 0–7 lock pages 8–15.
- R8: Stored lock bits affect write protection and freezing only after a `lock_refresh` pulse. Between pulses the effective copy does not change.
- R9: While an effective freeze bit is set, the lock bits it covers cannot be changed by a page 2 write. The write is still acknowledged, and the uncovered bits are still ORed in.
- R10: Command A0h to a writable page returns code Ah one cycle later and arms a frame phase. The next request is taken as the data frame, whatever its command byte. Only frame bytes 0–3 are written, and the write uses the same busy and acknowledge timing and merge rules as A2h. An A0h to a non-writable page returns 0h.
- R11: A request that arrives while a write is programming returns 0h one cycle later and has no effect. A request that lands on the completing edge is dropped. An unknown command byte returns 0h. A response that is not data carries only Ah or 0h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_cmd | input | 8 | Command byte (30h read, A2h write, A0h legacy write) |
| req_addr | input | 8 | Page address |
| req_data | input | FRAME_BYTES*8 | Data frame; byte n at bits [8n+7:8n] |
| lock_refresh | input | 1 | Pulse that loads the effective lock copy |
| busy | output | 1 | Page programming in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_is_data | output | 1 | Response carries read data |
| rsp_code | output | 4 | Ah acknowledge, 0h negative |
| rsp_data | output | READ_PAGES*32 | Read data, first page in the low word |

## Verification
The bench reads at 0Eh and 0Fh, where a design without modulo wrap would return unknown pages or repeat the last one. It writes lock bits and then tries to write the locked page before and after the refresh pulse. A design that applied locks at once would reject the first attempt, and one that ignored the refresh would accept the second. It sets a freeze bit and then tries to raise frozen and unfrozen lock bits in a single write. This catches a design that rejects the whole write, and one that lets frozen bits through. The legacy write puts non-zero bytes above byte 3, which exposes a design that spills them into the next page. A read issued during programming exposes a design that serves requests while busy.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
   localparam logic [7:0] CMD_READ   = 8'h30;
   localparam logic [7:0] CMD_WRITE  = 8'hA2;
   localparam logic [7:0] CMD_CWRITE = 8'hA0;
   localparam logic [3:0] CODE_ACK   = 4'hA;
   localparam logic [3:0] CODE_NAK   = 4'h0;
   localparam logic [7:0] CASCADE_TAG = 8'h88;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_FRAME = 2'd1,
      PH_PROG  = 2'd2
   } phase_t;

   function automatic logic [7:0] xor4(input logic [7:0] a, input logic [7:0] b,
                                       input logic [7:0] c, input logic [7:0] d);
      return a ^ b ^ c ^ d;
   endfunction
endpackage

// File: rtl/pgs_busy_timer.sv
module pgs_busy_timer #(
   parameter int BUSY_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CNT_W = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES - 1);

   if (BUSY_CYCLES < 1) begin : g_chk_cycles
      $error("BUSY_CYCLES must be at least 1");
   end

   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start && !busy_q) begin
         busy_q <= 1'b1;
         cnt_q  <= LOAD;
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign busy = busy_q;
   assign done = busy_q && (cnt_q == '0);

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LOAD);                                          // R4
   AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> (cnt_q == '0));                              // R4
endmodule

// File: rtl/pgs_lock_unit.sv
module pgs_lock_unit #(
   parameter int PAGES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             refresh,
   input  logic [15:0]      stored_lock,
   output logic [PAGES-1:0] writable,
   output logic [15:0]      frz
);
   logic [15:0] eff_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       eff_q <= '0;
      else if (refresh) eff_q <= stored_lock;
   end

   // index 0: page 3 freeze, 1: pages 4-9 freeze, 2: pages 10-15 freeze
   assign frz = {{6{eff_q[2]}}, {6{eff_q[1]}}, eff_q[0], 3'b000};

   for (genvar p = 0; p < PAGES; p++) begin : g_wr
      if (p < 2) begin : g_factory
         assign writable[p] = 1'b0;
      end else if (p == 2) begin : g_lockpage
         assign writable[p] = 1'b1;
      end else begin : g_locked
         assign writable[p] = ~eff_q[p];
      end
   end

   AST_EFF_ONLY_ON_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(refresh) |-> $stable(eff_q));                     // R8
endmodule

// File: rtl/pgs_page_array.sv
module pgs_page_array
   import pgs_pkg::*;
#(
   parameter int          PAGES      = 16,
   parameter int          WORD_W     = 32,
   parameter int          READ_PAGES = 4,
   parameter logic [55:0] SERIAL     = 56'h66554433221104,
   parameter logic [7:0]  RSVD_BYTE  = 8'h5A
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [$clog2(PAGES)-1:0]     wr_page,
   input  logic [WORD_W-1:0]            wr_data,
   input  logic [15:0]                  frz,
   input  logic [$clog2(PAGES)-1:0]     rd_page,
   output logic [READ_PAGES*WORD_W-1:0] rd_data,
   output logic [15:0]                  lock_bits
);
   localparam int PG_W = $clog2(PAGES);
   localparam logic [7:0] SN0 = SERIAL[7:0];
   localparam logic [7:0] SN1 = SERIAL[15:8];
   localparam logic [7:0] SN2 = SERIAL[23:16];
   localparam logic [7:0] SN3 = SERIAL[31:24];
   localparam logic [7:0] SN4 = SERIAL[39:32];
   localparam logic [7:0] SN5 = SERIAL[47:40];
   localparam logic [7:0] SN6 = SERIAL[55:48];
   localparam logic [7:0] CHK0 = xor4(CASCADE_TAG, SN0, SN1, SN2);
   localparam logic [7:0] CHK1 = xor4(SN3, SN4, SN5, SN6);

   logic [WORD_W-1:0] mem [PAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < PAGES; i++) mem[i] <= '0;
         mem[0] <= {CHK0, SN2, SN1, SN0};
         mem[1] <= {SN6, SN5, SN4, SN3};
         mem[2] <= {16'h0000, RSVD_BYTE, CHK1};
      end else if (wr_en) begin
         if (wr_page == PG_W'(2))
            mem[2][31:16] <= mem[2][31:16] | (wr_data[31:16] & ~frz);
         else if (wr_page == PG_W'(3))
            mem[3] <= mem[3] | wr_data;
         else
            mem[wr_page] <= wr_data;
      end
   end

   for (genvar k = 0; k < READ_PAGES; k++) begin : g_rd
      assign rd_data[k*WORD_W +: WORD_W] = mem[rd_page + PG_W'(k)];
   end

   assign lock_bits = mem[2][31:16];

   AST_FACTORY_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(mem[0]) && $stable(mem[1]) && $stable(mem[2][15:0]));   // R1
   AST_OTP_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mem[3]) & ~mem[3]) == '0);                                // R6
   AST_LOCK_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mem[2][31:16]) & ~mem[2][31:16]) == '0);                  // R7
   AST_FROZEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(frz) & ($past(mem[2][31:16]) ^ mem[2][31:16])) == '0);    // R9
endmodule

// File: rtl/page_store_ctrl.sv
module page_store_ctrl
   import pgs_pkg::*;
#(
   parameter int          PAGES       = 16,
   parameter int          PAGE_BYTES  = 4,
   parameter int          READ_PAGES  = 4,
   parameter int          FRAME_BYTES = 16,
   parameter int          BUSY_CYCLES = 16,
   parameter logic [55:0] SERIAL      = 56'h66554433221104,
   parameter logic [7:0]  RSVD_BYTE   = 8'h5A
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               req_valid,
   input  logic [7:0]                         req_cmd,
   input  logic [7:0]                         req_addr,
   input  logic [FRAME_BYTES*8-1:0]           req_data,
   input  logic                               lock_refresh,
   output logic                               busy,
   output logic                               rsp_valid,
   output logic                               rsp_is_data,
   output logic [3:0]                         rsp_code,
   output logic [READ_PAGES*PAGE_BYTES*8-1:0] rsp_data
);
   localparam int WORD_W = PAGE_BYTES * 8;
   localparam int PG_W   = $clog2(PAGES);
   localparam int RD_W   = READ_PAGES * WORD_W;

   if (PAGES != 16) begin : g_chk_pages
      $error("lock map needs exactly 16 pages");
   end
   if (PAGE_BYTES != 4) begin : g_chk_bytes
      $error("lock bytes need 4-byte pages");
   end
   if (READ_PAGES < 1 || READ_PAGES > PAGES) begin : g_chk_read
      $error("READ_PAGES out of range");
   end
   if (FRAME_BYTES < PAGE_BYTES) begin : g_chk_frame
      $error("frame shorter than a page");
   end

   phase_t             phase_q;
   logic [PG_W-1:0]    tgt_q;
   logic [WORD_W-1:0]  wdata_q;
   logic [PAGES-1:0]   writable;
   logic [15:0]        frz;
   logic [15:0]        lock_bits;
   logic [RD_W-1:0]    rd_data;
   logic               busy_w;
   logic               done_w;
   logic               start_w;
   logic               addr_ok;
   logic               can_write;
   logic [PG_W-1:0]    pg;
   logic               unused_frame_hi;

   assign pg        = req_addr[PG_W-1:0];
   assign addr_ok   = (req_addr >> PG_W) == '0;
   assign can_write = addr_ok && writable[pg];
   assign unused_frame_hi = ^req_data[FRAME_BYTES*8-1:WORD_W];

   assign start_w = req_valid && !done_w &&
                    ((phase_q == PH_FRAME) ||
                     (phase_q == PH_IDLE && req_cmd == CMD_WRITE && can_write));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         tgt_q       <= '0;
         wdata_q     <= '0;
         rsp_valid   <= 1'b0;
         rsp_is_data <= 1'b0;
         rsp_code    <= CODE_NAK;
         rsp_data    <= '0;
      end else begin
         rsp_valid   <= 1'b0;
         rsp_is_data <= 1'b0;
         if (done_w) begin
            rsp_valid <= 1'b1;
            rsp_code  <= CODE_ACK;
            phase_q   <= PH_IDLE;
         end else if (req_valid) begin
            rsp_valid <= 1'b1;
            rsp_code  <= CODE_NAK;
            case (phase_q)
               PH_FRAME: begin
                  rsp_valid <= 1'b0;
                  wdata_q   <= req_data[WORD_W-1:0];
                  phase_q   <= PH_PROG;
               end
               PH_IDLE: begin
                  case (req_cmd)
                     CMD_READ: begin
                        if (addr_ok) begin
                           rsp_is_data <= 1'b1;
                           rsp_code    <= CODE_ACK;
                           rsp_data    <= rd_data;
                        end
                     end
                     CMD_WRITE: begin
                        if (can_write) begin
                           rsp_valid <= 1'b0;
                           tgt_q     <= pg;
                           wdata_q   <= req_data[WORD_W-1:0];
                           phase_q   <= PH_PROG;
                        end
                     end
                     CMD_CWRITE: begin
                        if (can_write) begin
                           rsp_code <= CODE_ACK;
                           tgt_q    <= pg;
                           phase_q  <= PH_FRAME;
                        end
                     end
                     default: ;
                  endcase
               end
               default: ;
            endcase
         end else if (lock_refresh && phase_q == PH_FRAME) begin
            phase_q <= PH_IDLE;
         end
      end
   end

   pgs_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start_w),
      .busy  (busy_w),
      .done  (done_w)
   );

   pgs_lock_unit #(.PAGES(PAGES)) u_lock (
      .clk         (clk),
      .rst_n       (rst_n),
      .refresh     (lock_refresh),
      .stored_lock (lock_bits),
      .writable    (writable),
      .frz         (frz)
   );

   pgs_page_array #(
      .PAGES      (PAGES),
      .WORD_W     (WORD_W),
      .READ_PAGES (READ_PAGES),
      .SERIAL     (SERIAL),
      .RSVD_BYTE  (RSVD_BYTE)
   ) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (done_w),
      .wr_page   (tgt_q),
      .wr_data   (wdata_q),
      .frz       (frz),
      .rd_page   (pg),
      .rd_data   (rd_data),
      .lock_bits (lock_bits)
   );

   assign busy = busy_w;

   AST_PROG_MATCHES_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_PROG) == busy_w);                                   // R4
   AST_DATA_ONLY_FOR_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_is_data) |-> ($past(req_cmd) == CMD_READ));      // R2
   AST_RSP_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_is_data) |-> (rsp_code == CODE_ACK || rsp_code == CODE_NAK)); // R11
endmodule

// File: tb/sim_page_store_ctrl.sv
`timescale 1ns/1ps
module sim_page_store_ctrl;
   localparam int BUSY = 12;
   localparam logic [7:0] SN [7] = '{8'h04, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
   localparam logic [7:0] RSV = 8'h5A;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [7:0]   req_cmd = '0;
   logic [7:0]   req_addr = '0;
   logic [127:0] req_data = '0;
   logic         lock_refresh = 1'b0;
   logic         busy, rsp_valid, rsp_is_data;
   logic [3:0]   rsp_code;
   logic [127:0] rsp_data;

   int n_checks = 0;
   int n_fail   = 0;
   logic         r_valid, r_isd;
   logic [3:0]   r_code;
   logic [127:0] r_data;
   logic [31:0]  p0, p1, p2;

   always #4 clk = ~clk;

   page_store_ctrl #(.BUSY_CYCLES(BUSY)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
      .req_addr(req_addr), .req_data(req_data), .lock_refresh(lock_refresh),
      .busy(busy), .rsp_valid(rsp_valid), .rsp_is_data(rsp_is_data),
      .rsp_code(rsp_code), .rsp_data(rsp_data)
   );

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [7:0] cmd, input logic [7:0] addr,
                        input logic [127:0] data);
      @(negedge clk);
      req_valid = 1'b1; req_cmd = cmd; req_addr = addr; req_data = data;
      @(negedge clk);
      req_valid = 1'b0;
      r_valid = rsp_valid; r_isd = rsp_is_data; r_code = rsp_code; r_data = rsp_data;
   endtask

   task automatic wait_ack(input string req, input int k0);
      int k = k0;
      while (!rsp_valid && k < 1000) begin
         @(negedge clk);
         k++;
      end
      chk(k == BUSY && rsp_code == 4'hA && !rsp_is_data, req,
          {k[31:0], 28'h0, rsp_code}, {BUSY[31:0], 28'h0, 4'hA});
   endtask

   task automatic do_write(input logic [7:0] cmd, input logic [7:0] addr,
                           input logic [127:0] data, input bit expect_ok, input string req);
      issue(cmd, addr, data);
      if (expect_ok) begin
         chk(!r_valid && busy, req, {r_valid, busy}, 2'b01);
         wait_ack(req, 0);
      end else begin
         chk(r_valid && !r_isd && r_code == 4'h0 && !busy, req,
             {r_valid, r_isd, busy, r_code}, 7'b1000000);
      end
   endtask

   task automatic do_read(input logic [7:0] addr);
      issue(8'h30, addr, '0);
   endtask

   task automatic pulse_refresh();
      @(negedge clk); lock_refresh = 1'b1;
      @(negedge clk); lock_refresh = 1'b0;
   endtask

   task automatic t_reset();
      chk(!busy && !rsp_valid, "R1 idle outputs", {busy, rsp_valid}, 2'b00);
      do_read(8'h00);
      chk(r_valid && r_isd && r_data == {32'h0, p2, p1, p0}, "R1 factory layout",
          r_data, {32'h0, p2, p1, p0});
   endtask

   task automatic t_wrap();
      do_write(8'hA2, 8'h0F, {96'h0, 32'h0F0F1234}, 1'b1, "R4 write page 15");
      do_write(8'hA2, 8'h0E, {96'h0, 32'hDEADBEEF}, 1'b1, "R4 write page 14");
      do_read(8'h0E);
      chk(r_isd && r_data == {p1, p0, 32'h0F0F1234, 32'hDEADBEEF}, "R2 wrap from 0Eh",
          r_data, {p1, p0, 32'h0F0F1234, 32'hDEADBEEF});
      do_read(8'h0F);
      chk(r_isd && r_data == {p2, p1, p0, 32'h0F0F1234}, "R2 wrap from 0Fh",
          r_data, {p2, p1, p0, 32'h0F0F1234});
   endtask

   task automatic t_read_nak();
      do_read(8'h10);
      chk(r_valid && !r_isd && r_code == 4'h0, "R3 read 10h", {r_valid, r_isd, r_code}, 6'b100000);
      do_read(8'hFF);
      chk(r_valid && !r_isd && r_code == 4'h0, "R3 read FFh", {r_valid, r_isd, r_code}, 6'b100000);
   endtask

   task automatic t_reject();
      do_write(8'hA2, 8'h00, {96'h0, 32'hFFFFFFFF}, 1'b0, "R5 write page 0");
      do_write(8'hA2, 8'h01, {96'h0, 32'hFFFFFFFF}, 1'b0, "R5 write page 1");
      do_write(8'hA2, 8'h10, {96'h0, 32'hFFFFFFFF}, 1'b0, "R5 write addr 10h");
      do_read(8'h00);
      chk(r_data[95:0] == {p2, p1, p0}, "R5 factory untouched", r_data[95:0], {p2, p1, p0});
   endtask

   task automatic t_otp();
      do_write(8'hA2, 8'h03, {96'h0, 32'h0000000F}, 1'b1, "R6 otp first");
      do_write(8'hA2, 8'h03, {96'h0, 32'hA5000000}, 1'b1, "R6 otp second");
      do_write(8'hA2, 8'h03, {96'h0, 32'h00000000}, 1'b1, "R6 otp zero");
      do_read(8'h03);
      chk(r_data[31:0] == 32'hA500000F, "R6 otp OR", r_data[31:0], 32'hA500000F);
   endtask

   task automatic t_locks();
      do_write(8'hA2, 8'h04, {96'h0, 32'h11111111}, 1'b1, "R4 write page 4");
      do_write(8'hA2, 8'h02, {96'h0, 32'h0010AABB}, 1'b1, "R7 set L4");
      do_read(8'h02);
      chk(r_data[31:0] == 32'h00105A44, "R7 bytes 0-1 kept, OR lock", r_data[31:0], 32'h00105A44);
      do_write(8'hA2, 8'h04, {96'h0, 32'h22222222}, 1'b1, "R8 lock not yet effective");
      pulse_refresh();
      do_write(8'hA2, 8'h04, {96'h0, 32'h33333333}, 1'b0, "R8 lock effective after refresh");
      do_read(8'h04);
      chk(r_data[31:0] == 32'h22222222, "R5 locked page unchanged", r_data[31:0], 32'h22222222);
   endtask

   task automatic t_freeze();
      do_write(8'hA2, 8'h02, {96'h0, 32'h00040000}, 1'b1, "R9 set freeze 10-15");
      pulse_refresh();
      do_write(8'hA2, 8'h02, {96'h0, 32'hFF000000}, 1'b1, "R9 partial frozen write acked");
      do_read(8'h02);
      chk(r_data[31:0] == 32'h03145A44, "R9 frozen bits held", r_data[31:0], 32'h03145A44);
      pulse_refresh();
      do_write(8'hA2, 8'h0A, {96'h0, 32'h0A0A0A0A}, 1'b1, "R9 page 10 still writable");
      do_write(8'hA2, 8'h08, {96'h0, 32'h08080808}, 1'b0, "R9 page 8 now locked");
   endtask

   task automatic t_compat();
      issue(8'hA0, 8'h05, '0);
      chk(r_valid && !r_isd && r_code == 4'hA && !busy, "R10 address ack",
          {r_valid, r_isd, busy, r_code}, 7'b1001010);
      do_write(8'h00, 8'h00, {96'hFFFFFFFF_FFFFFFFF_FFFFFFFF, 32'hCAFEF00D}, 1'b1, "R10 frame ack");
      do_read(8'h05);
      chk(r_data[63:0] == {32'h0, 32'hCAFEF00D}, "R10 only bytes 0-3 written",
          r_data[63:0], {32'h0, 32'hCAFEF00D});
      do_write(8'hA0, 8'h01, '0, 1'b0, "R10 address nak page 1");
      do_write(8'hA0, 8'h04, '0, 1'b0, "R10 address nak locked page");
   endtask

   task automatic t_busy();
      issue(8'hA2, 8'h07, {96'h0, 32'h00000077});
      chk(!r_valid && busy, "R4 busy raised", {r_valid, busy}, 2'b01);
      req_valid = 1'b1; req_cmd = 8'h30; req_addr = 8'h00;
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid && !rsp_is_data && rsp_code == 4'h0, "R11 request while busy",
          {rsp_valid, rsp_is_data, rsp_code}, 6'b100000);
      @(negedge clk);
      wait_ack("R4 ack after busy", 2);
      do_read(8'h07);
      chk(r_data[31:0] == 32'h00000077, "R4 page 7 written", r_data[31:0], 32'h00000077);
      do_write(8'h55, 8'h05, '0, 1'b0, "R11 unknown command");
   endtask

   initial begin
      p0 = {8'h88 ^ SN[0] ^ SN[1] ^ SN[2], SN[2], SN[1], SN[0]};
      p1 = {SN[6], SN[5], SN[4], SN[3]};
      p2 = {16'h0, RSV, SN[3] ^ SN[4] ^ SN[5] ^ SN[6]};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_wrap();
      t_read_nak();
      t_reject();
      t_otp();
      t_locks();
      t_freeze();
      t_compat();
      t_busy();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(8 * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule